// File: doc/BRIEF.md
# Preemptible CAMAC Cycle Sequencer

This block turns queued CAMAC operations into a stream of individual cable cycles for one serial crate cable. It accepts two operation queues, one for time-critical (real-time) work and one for background (non-real-time) work. Each operation is either a single cycle, a control cycle, or a block transfer of several words. A block transfer may begin with a setup write, such as a pointer load, and each word may be carried as one 16-bit cycle or as two 16-bit halves of a 32-bit word.

Real-time operations take the cable at the next cycle boundary. A background transfer that is interrupted keeps its word position. When it resumes, its setup write is issued again with the data moved forward to the resume position, and then the remaining words follow. Paired halves are never split by a preemption, and a background operation can lock the cable for its whole duration. The cable engine sees a simple request/done handshake per cycle. Each finished operation produces a done pulse that tells which queue it came from and whether any of its cycles got no response.

Top module: `camac_preempt_seq`

## Requirements
- R1: When no cycle is outstanding, a held real-time operation is issued before any background cycle, unless a started background operation sits between two halves or holds its lock. A real-time operation that arrives while a background cycle is in flight is issued right after that cycle completes, subject to the same two exceptions.
- R2: When a started background operation with a setup write is preempted, the first cycle it issues after the real-time work is a setup write flagged as a replay. Its word field is the index of the next unfinished word, and its data is base plus that index. The transfer then continues at that word, and the replay does not advance the index.
- R3: After the first half (half=0) of a paired word, the next cycle issued is always the second half (half=1) of the same word, from the background queue.
- R4: A background operation with its lock flag set, once started, runs all its cycles before any real-time cycle.
- R5: An operation whose function code has bit 3 set (value 8) issues exactly one cycle with the no-data flag high, whatever its count and pairing.
- R6: A block transfer with setup enabled issues first a setup write (function 16, word 0, data = base). It then issues words 0 to count-1 in order, each as one cycle, or as half 0 then half 1 when pairing is set.
- R7: The cycles of a real-time operation are issued back to back, with no background cycle between them.
- R8: Each operation produces one op_done pulse after its last cycle completes, with op_rt telling the queue. op_err is high when any of that operation's cycles saw cyc_noresp, and the error does not carry into the next operation.
- R9: While cyc_req is high and cyc_done is low, all cycle fields hold steady. cyc_req falls in the cycle after cyc_done.
- R10: After reset, cyc_req and op_done are low and both queues are ready.
- R11: A preempted background operation without setup resumes directly at its next word, with no replay cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rt_valid | input | 1 | Real-time descriptor offered |
| rt_ready | output | 1 | Real-time slot free |
| rt_func | input | 5 | Real-time function code |
| rt_addr | input | 9 | Real-time station and subaddress |
| rt_count | input | 8 | Real-time word count |
| rt_pair | input | 1 | Real-time words carried as two halves |
| rt_setup | input | 1 | Real-time setup write enabled |
| rt_base | input | 16 | Real-time setup data base |
| nrt_valid | input | 1 | Background descriptor offered |
| nrt_ready | output | 1 | Background slot free |
| nrt_func | input | 5 | Background function code |
| nrt_addr | input | 9 | Background station and subaddress |
| nrt_count | input | 8 | Background word count |
| nrt_pair | input | 1 | Background words carried as two halves |
| nrt_lock | input | 1 | Background operation not interruptible |
| nrt_setup | input | 1 | Background setup write enabled |
| nrt_base | input | 16 | Background setup data base |
| cyc_req | output | 1 | Cycle request to cable engine |
| cyc_rt | output | 1 | Cycle belongs to real-time queue |
| cyc_func | output | 5 | Cycle function code |
| cyc_addr | output | 9 | Cycle address |
| cyc_word | output | 8 | Word index of cycle |
| cyc_half | output | 1 | Second half of a paired word |
| cyc_setup | output | 1 | Cycle is a setup write |
| cyc_replay | output | 1 | Setup write is a resume replay |
| cyc_nodata | output | 1 | Control cycle, no data |
| cyc_wdata | output | 16 | Setup write data |
| cyc_done | input | 1 | Cable engine finished cycle |
| cyc_noresp | input | 1 | Finished cycle got no response |
| op_done | output | 1 | Operation finished pulse |
| op_rt | output | 1 | Finished operation was real-time |
| op_err | output | 1 | Finished operation saw no-response |

## Verification
The main check is a sweep over every background configuration: pairing, setup write and lock flag, each on and off, with a real-time request injected after each possible cycle of a three-word transfer. Injection points next to a first half show whether the pair is kept together. Points inside a locked transfer show whether the lock defers the real-time work. Points after the setup cycle or after a word show whether the replay data follows the saved index, or whether no replay is issued when setup is off. Directed cases cover control codes with count and pairing set, simultaneous arrival on both queues, and a no-response on one cycle followed by a clean operation.

// File: rtl/camac_seq_pkg.sv
// Shared widths, constants and types for the preemptible CAMAC cycle sequencer.
// Assumes one cable and one outstanding cycle at a time.
package camac_seq_pkg;
    localparam int FUNC_W   = 5;
    localparam int ADDR_W   = 9;
    localparam int CNT_W    = 8;
    localparam int DATA_W   = 16;
    localparam int NQ       = 2;
    localparam int Q_RT     = 0;
    localparam int Q_NRT    = 1;
    localparam int CTRL_BIT = 3;
    localparam logic [FUNC_W-1:0] SETUP_FUNC = FUNC_W'(16);

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic              pair;
        logic              lock;
        logic              setup_en;
        logic [DATA_W-1:0] base;
    } op_desc_t;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  word;
        logic              half;
        logic              setup;
        logic              replay;
        logic              nodata;
        logic [DATA_W-1:0] data;
    } cyc_t;
endpackage

// File: rtl/camac_seq_ctx.sv
// Per-queue operation context: holds one descriptor and its progress
// (word index, half, pending setup write, error accumulation), presents the
// next cycle to issue, and advances when that cycle completes.
// Assumes adv and suspend never arrive in the same clock.
module camac_seq_ctx
    import camac_seq_pkg::*;
#(
    parameter bit CAN_SUSPEND = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  op_desc_t desc_in,
    input  logic     adv,
    input  logic     noresp,
    input  logic     suspend,
    output logic     busy,
    output cyc_t     cur,
    output logic     boundary_ok,
    output logic     started,
    output logic     done,
    output logic     err
);
    op_desc_t         d;
    logic [CNT_W-1:0] idx;
    logic             half;
    logic             need_setup;
    logic             replay;
    logic             err_acc;
    logic             is_ctrl;
    logic             last_cycle;
    logic [CNT_W:0]   idx_next;

    // Decode of the current position against the descriptor.
    always_comb begin
        is_ctrl    = d.func[CTRL_BIT];
        idx_next   = {1'b0, idx} + 1'b1;
        last_cycle = (!d.pair || half) && (idx_next >= {1'b0, d.count});
    end

    // Next cycle presented to the issue stage.
    always_comb begin
        cur.func   = need_setup ? SETUP_FUNC : d.func;
        cur.addr   = d.addr;
        cur.word   = idx;
        cur.half   = need_setup ? 1'b0 : half;
        cur.setup  = need_setup;
        cur.replay = replay;
        cur.nodata = !need_setup && is_ctrl;
        cur.data   = need_setup ? (d.base + DATA_W'(idx)) : '0;
        boundary_ok = busy && !half && !d.lock;
    end

    // Progress state: load, per-cycle advance, and suspension bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            d          <= '0;
            idx        <= '0;
            half       <= 1'b0;
            need_setup <= 1'b0;
            replay     <= 1'b0;
            err_acc    <= 1'b0;
            started    <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (load && !busy) begin
                busy       <= 1'b1;
                d          <= desc_in;
                idx        <= '0;
                half       <= 1'b0;
                need_setup <= desc_in.setup_en;
                replay     <= 1'b0;
                err_acc    <= 1'b0;
                started    <= 1'b0;
            end else if (busy && adv) begin
                started <= 1'b1;
                err_acc <= err_acc | noresp;
                if (need_setup) begin
                    need_setup <= 1'b0;
                    replay     <= 1'b0;
                end else if (is_ctrl || last_cycle) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    err  <= err_acc | noresp;
                end else if (d.pair && !half) begin
                    half <= 1'b1;
                end else begin
                    half <= 1'b0;
                    idx  <= idx_next[CNT_W-1:0];
                end
            end else if (CAN_SUSPEND && busy && suspend && started) begin
                need_setup <= d.setup_en;
                replay     <= d.setup_en;
            end
        end
    end

    // R2: a replay mark only exists while a setup write is pending.
    p_replay_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        replay |-> need_setup);

    // R6: the word index never runs past the descriptor's count.
    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && d.count != '0) |-> (idx < d.count));

    // R8: a done pulse lasts exactly one clock.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/camac_seq_arb.sv
// Issue arbiter: decides whether a free cable slot goes to the real-time or
// background context, and when to mark the background context as suspended.
// Assumes the real-time context itself is never interrupted.
module camac_seq_arb (
    input  logic slot_free,
    input  logic rt_busy,
    input  logic nrt_busy,
    input  logic nrt_started,
    input  logic nrt_boundary_ok,
    output logic issue,
    output logic pick_rt,
    output logic suspend_nrt
);
    logic rt_go;

    // Priority decision at a cycle boundary.
    always_comb begin
        rt_go       = rt_busy && (!nrt_busy || !nrt_started || nrt_boundary_ok);
        issue       = slot_free && (rt_go || nrt_busy);
        pick_rt     = rt_go;
        suspend_nrt = slot_free && rt_go && nrt_busy && nrt_started;
    end
endmodule

// File: rtl/camac_preempt_seq.sv
// Top of the preemptible CAMAC cycle sequencer. Holds one real-time and one
// background operation context, issues one cable cycle at a time through a
// request/done handshake, and reports completion per operation.
// Assumes the cable engine pulses cyc_done for one clock per request.
module camac_preempt_seq
    import camac_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rt_valid,
    output logic              rt_ready,
    input  logic [FUNC_W-1:0] rt_func,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [CNT_W-1:0]  rt_count,
    input  logic              rt_pair,
    input  logic              rt_setup,
    input  logic [DATA_W-1:0] rt_base,
    input  logic              nrt_valid,
    output logic              nrt_ready,
    input  logic [FUNC_W-1:0] nrt_func,
    input  logic [ADDR_W-1:0] nrt_addr,
    input  logic [CNT_W-1:0]  nrt_count,
    input  logic              nrt_pair,
    input  logic              nrt_lock,
    input  logic              nrt_setup,
    input  logic [DATA_W-1:0] nrt_base,
    output logic              cyc_req,
    output logic              cyc_rt,
    output logic [FUNC_W-1:0] cyc_func,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [CNT_W-1:0]  cyc_word,
    output logic              cyc_half,
    output logic              cyc_setup,
    output logic              cyc_replay,
    output logic              cyc_nodata,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic              cyc_done,
    input  logic              cyc_noresp,
    output logic              op_done,
    output logic              op_rt,
    output logic              op_err
);
    op_desc_t        q_desc [NQ];
    cyc_t            q_cur  [NQ];
    logic [NQ-1:0]   q_valid;
    logic [NQ-1:0]   q_busy;
    logic [NQ-1:0]   q_bound;
    logic [NQ-1:0]   q_started;
    logic [NQ-1:0]   q_done;
    logic [NQ-1:0]   q_err;
    logic [NQ-1:0]   q_adv;
    logic            issue;
    logic            pick_rt;
    logic            suspend_nrt;
    cyc_t            cyc_r;

    // Descriptor assembly from the two queue port groups.
    always_comb begin
        q_desc[Q_RT]  = '{func: rt_func, addr: rt_addr, count: rt_count,
                          pair: rt_pair, lock: 1'b0, setup_en: rt_setup,
                          base: rt_base};
        q_desc[Q_NRT] = '{func: nrt_func, addr: nrt_addr, count: nrt_count,
                          pair: nrt_pair, lock: nrt_lock, setup_en: nrt_setup,
                          base: nrt_base};
        q_valid[Q_RT]  = rt_valid;
        q_valid[Q_NRT] = nrt_valid;
    end

    // One context per queue; only the background one may be suspended.
    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign q_adv[q] = cyc_req && cyc_done && (cyc_rt == (q == Q_RT));
        camac_seq_ctx #(
            .CAN_SUSPEND(q == Q_NRT)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (q_valid[q]),
            .desc_in    (q_desc[q]),
            .adv        (q_adv[q]),
            .noresp     (cyc_noresp),
            .suspend    ((q == Q_NRT) ? suspend_nrt : 1'b0),
            .busy       (q_busy[q]),
            .cur        (q_cur[q]),
            .boundary_ok(q_bound[q]),
            .started    (q_started[q]),
            .done       (q_done[q]),
            .err        (q_err[q])
        );
    end

    camac_seq_arb u_arb (
        .slot_free      (!cyc_req),
        .rt_busy        (q_busy[Q_RT]),
        .nrt_busy       (q_busy[Q_NRT]),
        .nrt_started    (q_started[Q_NRT]),
        .nrt_boundary_ok(q_bound[Q_NRT]),
        .issue          (issue),
        .pick_rt        (pick_rt),
        .suspend_nrt    (suspend_nrt)
    );

    // Cycle request register: latch the chosen cycle, release on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_req <= 1'b0;
            cyc_rt  <= 1'b0;
            cyc_r   <= '0;
        end else if (cyc_req && cyc_done) begin
            cyc_req <= 1'b0;
        end else if (issue) begin
            cyc_req <= 1'b1;
            cyc_rt  <= pick_rt;
            cyc_r   <= pick_rt ? q_cur[Q_RT] : q_cur[Q_NRT];
        end
    end

    // Port outputs.
    always_comb begin
        rt_ready   = !q_busy[Q_RT];
        nrt_ready  = !q_busy[Q_NRT];
        cyc_func   = cyc_r.func;
        cyc_addr   = cyc_r.addr;
        cyc_word   = cyc_r.word;
        cyc_half   = cyc_r.half;
        cyc_setup  = cyc_r.setup;
        cyc_replay = cyc_r.replay;
        cyc_nodata = cyc_r.nodata;
        cyc_wdata  = cyc_r.data;
        op_done    = |q_done;
        op_rt      = q_done[Q_RT];
        op_err     = |q_err;
    end

    // R9: cycle fields hold while waiting for the engine.
    p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_done) |=> (cyc_req && $stable(cyc_r) && $stable(cyc_rt)));

    // R9: request drops right after completion.
    p_drop_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && cyc_done) |=> !cyc_req);

    // R3 and R4: a started background op mid-pair or locked keeps the cable.
    p_pair_lock_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_req && q_busy[Q_NRT] && q_started[Q_NRT] && !q_bound[Q_NRT])
        |=> (cyc_req && !cyc_rt));

    // R1: a held real-time op takes the next free slot when nothing blocks it.
    p_rt_next_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_req && q_busy[Q_RT] &&
         (!q_busy[Q_NRT] || !q_started[Q_NRT] || q_bound[Q_NRT]))
        |=> (cyc_req && cyc_rt));

    // R8: at most one operation completes per clock.
    p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_done));
endmodule

// File: tb/camac_preempt_seq_test.sv
`timescale 1ns/1ps
module camac_preempt_seq_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rt_valid = 1'b0, nrt_valid = 1'b0;
    logic        rt_ready, nrt_ready;
    logic [4:0]  rt_func = '0, nrt_func = '0;
    logic [8:0]  rt_addr = '0, nrt_addr = '0;
    logic [7:0]  rt_count = '0, nrt_count = '0;
    logic        rt_pair = 1'b0, rt_setup = 1'b0, nrt_pair = 1'b0;
    logic        nrt_lock = 1'b0, nrt_setup = 1'b0;
    logic [15:0] rt_base = '0, nrt_base = '0;
    logic        cyc_req, cyc_rt, cyc_half, cyc_setup, cyc_replay, cyc_nodata;
    logic [4:0]  cyc_func;
    logic [8:0]  cyc_addr;
    logic [7:0]  cyc_word;
    logic [15:0] cyc_wdata;
    logic        cyc_done = 1'b0, cyc_noresp = 1'b0;
    logic        op_done, op_rt, op_err;

    always #2.5 clk = ~clk;

    camac_preempt_seq uut (
        .clk(clk), .rst_n(rst_n),
        .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_func(rt_func),
        .rt_addr(rt_addr), .rt_count(rt_count), .rt_pair(rt_pair),
        .rt_setup(rt_setup), .rt_base(rt_base),
        .nrt_valid(nrt_valid), .nrt_ready(nrt_ready), .nrt_func(nrt_func),
        .nrt_addr(nrt_addr), .nrt_count(nrt_count), .nrt_pair(nrt_pair),
        .nrt_lock(nrt_lock), .nrt_setup(nrt_setup), .nrt_base(nrt_base),
        .cyc_req(cyc_req), .cyc_rt(cyc_rt), .cyc_func(cyc_func),
        .cyc_addr(cyc_addr), .cyc_word(cyc_word), .cyc_half(cyc_half),
        .cyc_setup(cyc_setup), .cyc_replay(cyc_replay), .cyc_nodata(cyc_nodata),
        .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_noresp(cyc_noresp),
        .op_done(op_done), .op_rt(op_rt), .op_err(op_err)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [33:0] got [0:63];
    logic [33:0] expv [0:63];
    int ng = 0, ne = 0;
    int inj_k = -1, err_at = -1;
    bit rt_drop = 1'b0;
    int wcnt = 0, stab_bad = 0;
    logic [33:0] snap;
    int n_rt_done = 0, n_nrt_done = 0;
    bit rt_err_seen = 1'b0, nrt_err_seen = 1'b0;

    function automatic logic [33:0] pk(input bit rt, input bit su, input bit rp,
        input bit nd, input bit hf, input logic [4:0] fn, input logic [7:0] w,
        input logic [15:0] dt);
        return {rt, su, rp, nd, hf, fn, w, dt};
    endfunction

    function automatic logic [33:0] now_cyc();
        return pk(cyc_rt, cyc_setup, cyc_replay, cyc_nodata, cyc_half,
                  cyc_func, cyc_word, cyc_wdata);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cable engine model, completion monitor and real-time injection.
    initial begin
        forever begin
            @(negedge clk);
            if (op_done) begin
                if (op_rt) begin n_rt_done++; rt_err_seen = op_err; end
                else begin n_nrt_done++; nrt_err_seen = op_err; end
            end
            if (rt_drop) begin rt_valid = 1'b0; rt_drop = 1'b0; end
            if (cyc_done) begin
                cyc_done = 1'b0; cyc_noresp = 1'b0; wcnt = 0;
            end else if (cyc_req) begin
                if (wcnt == 0) snap = now_cyc();
                else if (now_cyc() !== snap) stab_bad++;
                if (wcnt == LAT) begin
                    if (ng < 64) got[ng] = now_cyc();
                    if (ng == err_at) cyc_noresp = 1'b1;
                    if (ng == inj_k) begin
                        rt_func = 5'd0; rt_addr = 9'h011; rt_count = 8'd2;
                        rt_pair = 1'b0; rt_setup = 1'b0; rt_base = '0;
                        rt_valid = 1'b1; rt_drop = 1'b1; inj_k = -1;
                    end
                    ng++;
                    cyc_done = 1'b1;
                end else wcnt++;
            end
        end
    end

    task automatic clear_run();
        ng = 0; ne = 0; n_rt_done = 0; n_nrt_done = 0;
        rt_err_seen = 1'b0; nrt_err_seen = 1'b0; err_at = -1; inj_k = -1;
    endtask

    task automatic push(input logic [33:0] v);
        expv[ne] = v; ne++;
    endtask

    task automatic set_nrt(input logic [4:0] fn, input logic [7:0] cnt,
        input bit pr, input bit lk, input bit su, input logic [15:0] bs);
        nrt_func = fn; nrt_addr = 9'h0A5; nrt_count = cnt; nrt_pair = pr;
        nrt_lock = lk; nrt_setup = su; nrt_base = bs;
    endtask

    task automatic wait_ops(input int nrt_n, input int rt_n);
        while (!(n_nrt_done == nrt_n && n_rt_done == rt_n)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_log(input string tag);
        int bad = -1;
        for (int i = 0; i < ne; i++)
            if (bad < 0 && got[i] !== expv[i]) bad = i;
        if (ng != ne) check(1'b0, {tag, " cycle count"}, 64'(ng), 64'(ne));
        else if (bad >= 0)
            check(1'b0, $sformatf("%s cycle %0d", tag, bad),
                  64'(got[bad]), 64'(expv[bad]));
        else check(1'b1, tag, 0, 0);
    endtask

    // Expected sequence for a background transfer with a two-word real-time
    // read injected when background cycle k completes.
    task automatic exp_preempt(input int cnt, input bit pr, input bit su,
        input bit lk, input logic [15:0] bs, input int k);
        logic [33:0] it [0:31];
        int wd [0:31];
        bit hf [0:31];
        int n = 0, j;
        if (su) begin it[n] = pk(0,1,0,0,0,5'd16,8'd0,bs); wd[n] = 0; hf[n] = 0; n++; end
        for (int w = 0; w < cnt; w++) begin
            it[n] = pk(0,0,0,0,0,5'd2,8'(w),16'd0); wd[n] = w; hf[n] = 0; n++;
            if (pr) begin
                it[n] = pk(0,0,0,0,1,5'd2,8'(w),16'd0); wd[n] = w; hf[n] = 1; n++;
            end
        end
        if (lk || k >= n - 1) j = n - 1;
        else begin
            j = k;
            while (j < n - 1 && hf[j+1]) j++;
        end
        for (int i = 0; i <= j; i++) push(it[i]);
        push(pk(1,0,0,0,0,5'd0,8'd0,16'd0));
        push(pk(1,0,0,0,0,5'd0,8'd1,16'd0));
        if (j < n - 1 && su)
            push(pk(0,1,1,0,0,5'd16,8'(wd[j+1]),bs + 16'(wd[j+1])));
        for (int i = j + 1; i < n; i++) push(it[i]);
    endtask

    function automatic int item_count(input int cnt, input bit pr, input bit su);
        return (su ? 1 : 0) + cnt * (pr ? 2 : 1);
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(cyc_req == 1'b0, "R10 cyc_req", 64'(cyc_req), 0);
        check(op_done == 1'b0, "R10 op_done", 64'(op_done), 0);
        check(rt_ready && nrt_ready, "R10 ready", 64'({rt_ready, nrt_ready}), 64'h3);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: plain block transfer with setup, no interruption
        clear_run();
        set_nrt(5'd2, 8'd4, 1'b0, 1'b0, 1'b1, 16'h0050);
        nrt_valid = 1'b1; @(negedge clk); nrt_valid = 1'b0;
        wait_ops(1, 0);
        push(pk(0,1,0,0,0,5'd16,8'd0,16'h0050));
        for (int w = 0; w < 4; w++) push(pk(0,0,0,0,0,5'd2,8'(w),16'd0));
        compare_log("R6 block transfer");
        check(nrt_err_seen == 1'b0, "R8 clean op_err", 64'(nrt_err_seen), 0);

        // R5: control code with count and pairing set
        clear_run();
        set_nrt(5'd9, 8'd5, 1'b1, 1'b0, 1'b0, 16'h0000);
        nrt_valid = 1'b1; @(negedge clk); nrt_valid = 1'b0;
        wait_ops(1, 0);
        push(pk(0,0,0,1,0,5'd9,8'd0,16'd0));
        compare_log("R5 control func 9");

        // R5: control code on the real-time queue
        clear_run();
        rt_func = 5'd24; rt_count = 8'd3; rt_pair = 1'b0; rt_setup = 1'b0;
        rt_valid = 1'b1; @(negedge clk); rt_valid = 1'b0;
        wait_ops(0, 1);
        push(pk(1,0,0,1,0,5'd24,8'd0,16'd0));
        compare_log("R5 control func 24");

        // R1 R7: both queues offered together; real-time paired op runs whole first
        clear_run();
        set_nrt(5'd2, 8'd2, 1'b0, 1'b1, 1'b1, 16'h0200);
        rt_func = 5'd1; rt_count = 8'd2; rt_pair = 1'b1; rt_setup = 1'b1; rt_base = 16'h0030;
        rt_valid = 1'b1; nrt_valid = 1'b1; @(negedge clk);
        rt_valid = 1'b0; nrt_valid = 1'b0;
        wait_ops(1, 1);
        push(pk(1,1,0,0,0,5'd16,8'd0,16'h0030));
        push(pk(1,0,0,0,0,5'd1,8'd0,16'd0)); push(pk(1,0,0,0,1,5'd1,8'd0,16'd0));
        push(pk(1,0,0,0,0,5'd1,8'd1,16'd0)); push(pk(1,0,0,0,1,5'd1,8'd1,16'd0));
        push(pk(0,1,0,0,0,5'd16,8'd0,16'h0200));
        push(pk(0,0,0,0,0,5'd2,8'd0,16'd0)); push(pk(0,0,0,0,0,5'd2,8'd1,16'd0));
        compare_log("R1 R7 simultaneous arrival");

        // R8: no-response on one cycle flags that op only
        clear_run();
        err_at = 1;
        set_nrt(5'd2, 8'd3, 1'b0, 1'b0, 1'b0, 16'h0000);
        nrt_valid = 1'b1; @(negedge clk); nrt_valid = 1'b0;
        wait_ops(1, 0);
        check(nrt_err_seen == 1'b1, "R8 op_err set", 64'(nrt_err_seen), 1);
        clear_run();
        set_nrt(5'd2, 8'd1, 1'b0, 1'b0, 1'b0, 16'h0000);
        nrt_valid = 1'b1; @(negedge clk); nrt_valid = 1'b0;
        wait_ops(1, 0);
        check(nrt_err_seen == 1'b0, "R8 op_err cleared", 64'(nrt_err_seen), 0);
        check(n_nrt_done == 1, "R8 one done pulse", 64'(n_nrt_done), 1);

        // R1 R2 R3 R4 R11: injection sweep over every background cycle
        for (int cfg = 0; cfg < 8; cfg++) begin
            bit pr = cfg[0], su = cfg[1], lk = cfg[2];
            int n = item_count(3, pr, su);
            for (int k = 0; k < n; k++) begin
                string tag;
                tag = lk ? "R4" : (pr ? "R3" : (su ? "R2" : "R11"));
                clear_run();
                inj_k = k;
                set_nrt(5'd2, 8'd3, pr, lk, su, 16'h0100 + 16'(cfg));
                nrt_valid = 1'b1; @(negedge clk); nrt_valid = 1'b0;
                wait_ops(1, 1);
                exp_preempt(3, pr, su, lk, 16'h0100 + 16'(cfg), k);
                compare_log($sformatf("%s R1 sweep cfg=%0d k=%0d", tag, cfg, k));
            end
        end

        // R9: fields stable across every wait
        check(stab_bad == 0, "R9 field stability", 64'(stab_bad), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule